// File: doc/BRIEF.md
# Host-to-Local Bus Width Splitter

This block takes a single 32-bit host access and turns it into the series of transfers that a local bus needs when that bus is 8, 16 or 32 bits wide. The width is chosen per access. A request carries four byte enables. Only the parts of the word whose enables are set produce local transfers, so a partial write to a narrow peripheral takes as few local cycles as possible. Read returns from a narrow bus are gathered into a 32-bit holding word. That word is handed back together with a one-cycle completion pulse.

Byte ordering is selectable per access. In big-endian ordering, local byte address `a` corresponds to host byte lane `3-a`, for data and for enables alike. A separate lane-redirect option places narrow traffic on the top of the local data bus instead of the bottom. With it, 8-bit transfers use lane 3 and 16-bit transfers use lanes 3:2. Each sub-transfer is presented for exactly one cycle, with the longword address and the generated low address bits. The block does not model local wait states or the host bus protocol.

Top module: `bus_width_splitter`

## Requirements
- R1: `width_sel` picks the local width per access: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 or 2'b11 = 32 bits.
- R2: On an 8-bit bus, one transfer is issued for each enabled local byte address, in ascending order of `loc_addr_lo`. Disabled bytes produce no transfer. `loc_be` has exactly one bit set, and the data byte sits on that lane with the other lanes zero.
- R3: On a 16-bit bus, one transfer is issued for each half-word (`loc_addr_lo` 0, then 2) that has at least one enabled byte. The half-word's two enables are passed through on its lanes, and both data bytes of the half-word are driven.
- R4: On a 32-bit bus, a request with any enable set gives exactly one transfer with `loc_addr_lo` = 0, `loc_be` equal to the (ordered) enables, and the full (ordered) word.
- R5: With `big_endian` = 1, local byte address `a` carries host byte lane `3-a`. This holds for write data, byte enables and read data. With `big_endian` = 0, local byte address `a` carries host byte lane `a`.
- R6: With `lane_redirect` = 1, 8-bit transfers use lane 3 (`loc_be` = 4'b1000). 16-bit transfers use lanes 3:2, so `loc_be[1:0]` = 0 and data is in bits 31:16. At 32 bits the option has no effect.
- R7: For reads, each returned byte of an enabled local address is placed into its host byte of `rd_data`. Host bytes without an enable read as zero. `rd_data` is valid in the cycle `done` is high.
- R8: `loc_valid` is high in consecutive cycles starting the cycle after acceptance, one cycle per sub-transfer. `done` pulses for one cycle in the cycle after the last sub-transfer. A request with all enables clear gives no transfer and `done` in the cycle after acceptance.
- R9: `req_ready` is low from acceptance until `done`. Request inputs presented while it is low are ignored and do not change the ongoing sequence.
- R10: After reset, `loc_valid` and `done` are low and `req_ready` is high.
- R11: `loc_addr_hi` equals the longword address of the accepted request during every one of its sub-transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Longword address (host address bits above 1:0) |
| req_be | input | 4 | Host byte enables, bit i = host lane i |
| req_wdata | input | 32 | Host write data |
| width_sel | input | 2 | Local width select (see R1) |
| big_endian | input | 1 | Byte ordering select (see R5) |
| lane_redirect | input | 1 | Narrow traffic on upper lanes (see R6) |
| loc_valid | output | 1 | Sub-transfer present this cycle |
| loc_write | output | 1 | Direction of the sub-transfer |
| loc_addr_hi | output | ADDR_W | Longword address of the sub-transfer |
| loc_addr_lo | output | 2 | Byte/half-word address bits of the sub-transfer |
| loc_be | output | 4 | Local byte-lane enables |
| loc_wdata | output | 32 | Local write data, placed on the active lanes |
| loc_rdata | input | 32 | Local read data, valid in the cycle of the sub-transfer |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Assembled read word, valid with `done` |

## Verification
A wrong pending mask shows at once in the transfer stream. In the cycle after acceptance, a lost or duplicated unit appears as a missing, repeated or out-of-order `loc_addr_lo`, or as a `done` pulse one cycle early or late. A wrong latched ordering or redirect flag shows in the first sub-transfer's `loc_be` and lane placement. A holding-word error only becomes visible in `rd_data` at the `done` pulse, so every enable pattern is run in read form as well, under both orderings and both lane placements. Request inputs are scrambled during each sequence, so that a control field that is not held by the block shows up on the next sub-transfer.

// File: rtl/bws_pkg.sv
// Package: shared types and helpers for the bus width splitter.
// Assumes a 32-bit host word split into four byte lanes.
package bws_pkg;

    localparam int LANES = 4;
    localparam int WORD_W = 8 * LANES;
    localparam int LO_W = $clog2(LANES);

    typedef enum logic [1:0] {
        BW_8  = 2'b00,
        BW_16 = 2'b01,
        BW_32 = 2'b10
    } bus_width_e;

    // Map the width select pins to a width; both upper codes mean 32 bits.
    function automatic bus_width_e decode_width(input logic [1:0] sel);
        case (sel)
            2'b00:   return BW_8;
            2'b01:   return BW_16;
            default: return BW_32;
        endcase
    endfunction

    // Reverse the byte order of a word.
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < LANES; i++) r[8*i +: 8] = w[8*(LANES-1-i) +: 8];
        return r;
    endfunction

    // Reverse the order of per-lane enable bits.
    function automatic logic [LANES-1:0] swap_en(input logic [LANES-1:0] e);
        logic [LANES-1:0] r;
        for (int i = 0; i < LANES; i++) r[i] = e[LANES-1-i];
        return r;
    endfunction

endpackage

// File: rtl/bws_unit_pick.sv
// Module: bws_unit_pick
// Picks the lowest pending transfer unit and flags whether it is the last one.
// Assumes the pending mask is indexed by unit number (byte, half-word or word).
module bws_unit_pick
    import bws_pkg::*;
(
    input  logic [LANES-1:0] pend,
    output logic [LO_W-1:0]  idx,
    output logic             last
);

    // Lowest set bit wins, so units go out in ascending address order.
    always_comb begin
        idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) idx = LO_W'(i);
        end
        last = ((pend & ~(LANES'(1) << idx)) == '0);
    end

endmodule

// File: rtl/bws_lane_route.sv
// Module: bws_lane_route
// Places the current unit's data and enables on the local lanes and tells the
// read gatherer which lane feeds each local byte address.
// Assumes data and enables are already in local byte-address order.
module bws_lane_route
    import bws_pkg::*;
(
    input  bus_width_e                mode,
    input  logic                      redir,
    input  logic [LO_W-1:0]           idx,
    input  logic [LANES-1:0]          sbe,
    input  logic [WORD_W-1:0]         swdata,
    output logic [LANES-1:0]          loc_be,
    output logic [WORD_W-1:0]         loc_wdata,
    output logic [LANES-1:0][LO_W-1:0] lane_sel,
    output logic [LANES-1:0]          in_unit
);

    logic [LO_W-1:0] lane8;
    logic [LO_W-1:0] base16;

    // Lane position chosen by the redirect option for narrow widths.
    always_comb begin
        lane8  = redir ? LO_W'(LANES - 1) : '0;
        base16 = redir ? LO_W'(LANES / 2) : '0;
    end

    // Width-dependent routing of enables, data and read lanes.
    always_comb begin
        loc_be    = '0;
        loc_wdata = '0;
        lane_sel  = '0;
        in_unit   = '0;
        case (mode)
            BW_8: begin
                loc_be    = LANES'(1) << lane8;
                loc_wdata = {{(WORD_W-8){1'b0}}, swdata[idx*8 +: 8]} << (8 * lane8);
                for (int a = 0; a < LANES; a++) begin
                    lane_sel[a] = lane8;
                    in_unit[a]  = (LO_W'(a) == idx);
                end
            end
            BW_16: begin
                loc_be    = {{(LANES-2){1'b0}}, sbe[idx[0]*2 +: 2]} << base16;
                loc_wdata = {{(WORD_W-16){1'b0}}, swdata[idx[0]*16 +: 16]} << (8 * base16);
                for (int a = 0; a < LANES; a++) begin
                    lane_sel[a] = base16 | {{(LO_W-1){1'b0}}, a[0]};
                    in_unit[a]  = (a[1] == idx[0]);
                end
            end
            default: begin
                loc_be    = sbe;
                loc_wdata = swdata;
                for (int a = 0; a < LANES; a++) begin
                    lane_sel[a] = LO_W'(a);
                    in_unit[a]  = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/bws_read_gather.sv
// Module: bws_read_gather
// Holding word for narrow reads, kept in local byte-address order.
// Assumes clear and capture are never high together.
module bws_read_gather
    import bws_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       capture,
    input  logic [LANES-1:0]           sbe,
    input  logic [LANES-1:0]           in_unit,
    input  logic [LANES-1:0][LO_W-1:0] lane_sel,
    input  logic [WORD_W-1:0]          loc_rdata,
    output logic [WORD_W-1:0]          hold_next
);

    logic [WORD_W-1:0] hold_q;

    // Next holding value: cleared per access, enabled bytes of this unit loaded.
    always_comb begin
        hold_next = hold_q;
        if (clear) begin
            hold_next = '0;
        end else if (capture) begin
            for (int a = 0; a < LANES; a++) begin
                if (sbe[a] && in_unit[a]) hold_next[8*a +: 8] = loc_rdata[8*lane_sel[a] +: 8];
            end
        end
    end

    // Holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_next;
    end

endmodule

// File: rtl/bus_width_splitter.sv
// Module: bus_width_splitter
// Splits one 32-bit host access into 8-, 16- or 32-bit local transfers,
// skipping units with no enabled byte, and gathers narrow read returns.
// Assumes the local side accepts one sub-transfer per cycle and returns
// read data in the same cycle.
module bus_width_splitter
    import bws_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    input  logic [1:0]        width_sel,
    input  logic              big_endian,
    input  logic              lane_redirect,
    output logic              loc_valid,
    output logic              loc_write,
    output logic [ADDR_W-1:0] loc_addr_hi,
    output logic [1:0]        loc_addr_lo,
    output logic [3:0]        loc_be,
    output logic [31:0]       loc_wdata,
    input  logic [31:0]       loc_rdata,
    output logic              done,
    output logic [31:0]       rd_data
);

    logic                       busy_q;
    logic [LANES-1:0]           pend_q;
    bus_width_e                 mode_q;
    logic                       redir_q;
    logic                       bend_q;
    logic                       write_q;
    logic [ADDR_W-1:0]          addr_q;
    logic [LANES-1:0]           sbe_q;
    logic [WORD_W-1:0]          swdata_q;
    logic                       accept;
    bus_width_e                 new_mode;
    logic [LANES-1:0]           new_sbe;
    logic [LANES-1:0]           new_pend;
    logic [LO_W-1:0]            idx;
    logic                       last;
    logic [LANES-1:0][LO_W-1:0] lane_sel;
    logic [LANES-1:0]           in_unit;
    logic [WORD_W-1:0]          hold_next;

    // Request acceptance and request-side decoding.
    always_comb begin
        accept   = req_valid && !busy_q;
        new_mode = decode_width(width_sel);
        new_sbe  = big_endian ? swap_en(req_be) : req_be;
        case (new_mode)
            BW_8:    new_pend = new_sbe;
            BW_16:   new_pend = {2'b00, |new_sbe[3:2], |new_sbe[1:0]};
            default: new_pend = {3'b000, |new_sbe};
        endcase
    end

    bws_unit_pick u_pick (
        .pend (pend_q),
        .idx  (idx),
        .last (last)
    );

    bws_lane_route u_route (
        .mode      (mode_q),
        .redir     (redir_q),
        .idx       (idx),
        .sbe       (sbe_q),
        .swdata    (swdata_q),
        .loc_be    (loc_be),
        .loc_wdata (loc_wdata),
        .lane_sel  (lane_sel),
        .in_unit   (in_unit)
    );

    bws_read_gather u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (busy_q && !write_q),
        .sbe       (sbe_q),
        .in_unit   (in_unit),
        .lane_sel  (lane_sel),
        .loc_rdata (loc_rdata),
        .hold_next (hold_next)
    );

    // Sequencer: latch the request, retire one unit per cycle, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            pend_q   <= '0;
            mode_q   <= BW_8;
            redir_q  <= 1'b0;
            bend_q   <= 1'b0;
            write_q  <= 1'b0;
            addr_q   <= '0;
            sbe_q    <= '0;
            swdata_q <= '0;
            done     <= 1'b0;
            rd_data  <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                mode_q   <= new_mode;
                redir_q  <= lane_redirect;
                bend_q   <= big_endian;
                write_q  <= req_write;
                addr_q   <= req_addr;
                sbe_q    <= new_sbe;
                swdata_q <= big_endian ? swap_bytes(req_wdata) : req_wdata;
                pend_q   <= new_pend;
                busy_q   <= |new_pend;
                if (new_pend == '0) begin
                    done    <= 1'b1;
                    rd_data <= '0;
                end
            end else if (busy_q) begin
                pend_q <= pend_q & ~(LANES'(1) << idx);
                if (last) begin
                    busy_q  <= 1'b0;
                    done    <= 1'b1;
                    rd_data <= bend_q ? swap_bytes(hold_next) : hold_next;
                end
            end
        end
    end

    // Local-side address and control outputs.
    always_comb begin
        req_ready   = !busy_q;
        loc_valid   = busy_q;
        loc_write   = write_q;
        loc_addr_hi = addr_q;
        case (mode_q)
            BW_8:    loc_addr_lo = idx;
            BW_16:   loc_addr_lo = {idx[0], 1'b0};
            default: loc_addr_lo = 2'b00;
        endcase
    end

    // R2
    w8_single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && mode_q == BW_8) |-> ($countones(loc_be) == 1));

    // R2 R3
    ascending_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && $past(loc_valid)) |-> (loc_addr_lo > $past(loc_addr_lo)));

    // R6
    upper_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && redir_q && mode_q != BW_32) |-> (loc_be[1:0] == 2'b00));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!loc_valid && req_ready));

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && $past(loc_valid)) |-> (loc_addr_hi == $past(loc_addr_hi)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && !last) |=> loc_valid);

endmodule

// File: tb/sim_bus_width_splitter.sv
// Bench: behavioural reference model (queues of expected sub-transfers)
// compared against the ports at every negative clock edge.
module sim_bus_width_splitter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  width_sel = '0;
    logic        big_endian = 1'b0;
    logic        lane_redirect = 1'b0;
    logic        loc_valid;
    logic        loc_write;
    logic [25:0] loc_addr_hi;
    logic [1:0]  loc_addr_lo;
    logic [3:0]  loc_be;
    logic [31:0] loc_wdata;
    logic [31:0] loc_rdata;
    logic        done;
    logic [31:0] rd_data;

    int n_run = 0;
    int n_fail = 0;

    int          q_lo[$];
    logic [3:0]  q_be[$];
    logic [31:0] q_wd[$];
    logic [31:0] exp_rd;

    always #4 clk = ~clk;

    bus_width_splitter #(.ADDR_W(26)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .width_sel(width_sel), .big_endian(big_endian),
        .lane_redirect(lane_redirect), .loc_valid(loc_valid), .loc_write(loc_write),
        .loc_addr_hi(loc_addr_hi), .loc_addr_lo(loc_addr_lo), .loc_be(loc_be),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .done(done), .rd_data(rd_data)
    );

    function automatic logic [7:0] rbyte(input int lo, input int lane);
        return 8'((lo + 1) * 16 + lane + 5);
    endfunction

    // Local memory model: each lane returns a value tied to address and lane.
    always_comb begin
        for (int l = 0; l < 4; l++) loc_rdata[8*l +: 8] = rbyte(int'(loc_addr_lo), l);
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Build the expected transfer list and read word from the requirements.
    task automatic build_model(input logic wr, input logic [1:0] wsel, input bit bend,
                               input bit redir, input logic [3:0] be, input logic [31:0] wd);
        logic [3:0]  sb;
        logic [31:0] sd;
        int          lane8;
        int          base;
        q_lo.delete(); q_be.delete(); q_wd.delete();
        exp_rd = '0;
        for (int a = 0; a < 4; a++) begin
            sb[a]        = bend ? be[3-a] : be[a];
            sd[8*a +: 8] = bend ? wd[8*(3-a) +: 8] : wd[8*a +: 8];
        end
        lane8 = redir ? 3 : 0;
        base  = redir ? 2 : 0;
        if (wsel == 2'b00) begin
            for (int a = 0; a < 4; a++) begin
                if (sb[a]) begin
                    q_lo.push_back(a);
                    q_be.push_back(4'(1 << lane8));
                    q_wd.push_back(32'(sd[8*a +: 8]) << (8 * lane8));
                    exp_rd[8*(bend ? 3-a : a) +: 8] = rbyte(a, lane8);
                end
            end
        end else if (wsel == 2'b01) begin
            for (int j = 0; j < 2; j++) begin
                if (sb[2*j] || sb[2*j+1]) begin
                    q_lo.push_back(2 * j);
                    q_be.push_back(4'({sb[2*j+1], sb[2*j]}) << base);
                    q_wd.push_back(32'(sd[16*j +: 16]) << (8 * base));
                    for (int k = 0; k < 2; k++) begin
                        if (sb[2*j+k]) exp_rd[8*(bend ? 3-(2*j+k) : 2*j+k) +: 8] = rbyte(2*j, base + k);
                    end
                end
            end
        end else begin
            if (sb != 4'b0000) begin
                q_lo.push_back(0);
                q_be.push_back(sb);
                q_wd.push_back(sd);
                for (int a = 0; a < 4; a++) begin
                    if (sb[a]) exp_rd[8*(bend ? 3-a : a) +: 8] = rbyte(0, a);
                end
            end
        end
        if (wr) exp_rd = '0;
    endtask

    // Run one access: entered and left at a negative edge.
    task automatic run_access(input logic wr, input logic [1:0] wsel, input bit bend,
                              input bit redir, input logic [3:0] be, input logic [31:0] wd,
                              input logic [25:0] addr);
        string tag;
        string be_tag;
        string wd_tag;
        build_model(wr, wsel, bend, redir, be, wd);
        tag    = (wsel == 2'b11) ? "R1" : (wsel == 2'b00) ? "R2" : (wsel == 2'b01) ? "R3" : "R4";
        be_tag = (redir && wsel[1] == 1'b0) ? "R6" : (bend ? "R5" : tag);
        wd_tag = bend ? "R5" : tag;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be;
        req_wdata = wd; width_sel = wsel; big_endian = bend; lane_redirect = redir;
        @(negedge clk);
        while (q_lo.size() > 0) begin
            chk("R8", "loc_valid", 32'(loc_valid), 32'd1);
            chk("R8", "done during sequence", 32'(done), 32'd0);
            chk("R9", "req_ready while busy", 32'(req_ready), 32'd0);
            chk(tag, "loc_addr_lo", 32'(loc_addr_lo), 32'(q_lo[0]));
            chk(be_tag, "loc_be", 32'(loc_be), 32'(q_be[0]));
            chk(tag, "loc_write", 32'(loc_write), 32'(wr));
            chk("R11", "loc_addr_hi", 32'(loc_addr_hi), 32'(addr));
            if (wr) chk(wd_tag, "loc_wdata", loc_wdata, q_wd[0]);
            void'(q_lo.pop_front()); void'(q_be.pop_front()); void'(q_wd.pop_front());
            // Scramble request inputs while busy; they must be ignored.
            req_addr = ~addr; req_be = ~be; req_wdata = ~wd; req_write = ~wr;
            width_sel = ~wsel; big_endian = ~bend; lane_redirect = ~redir;
            @(negedge clk);
        end
        chk("R8", "done pulse", 32'(done), 32'd1);
        chk("R8", "loc_valid after last", 32'(loc_valid), 32'd0);
        chk("R9", "req_ready at done", 32'(req_ready), 32'd1);
        if (!wr) chk(bend ? "R5" : "R7", "rd_data", rd_data, exp_rd);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8", "done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        logic [3:0] be_set[6];
        int         n;
        be_set = '{4'hF, 4'b0101, 4'b1000, 4'b0110, 4'b0000, 4'b1011};
        repeat (3) @(negedge clk);
        chk("R10", "loc_valid in reset", 32'(loc_valid), 32'd0);
        chk("R10", "done in reset", 32'(done), 32'd0);
        chk("R10", "req_ready in reset", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "loc_valid after reset", 32'(loc_valid), 32'd0);
        n = 0;
        for (int w = 0; w < 3; w++) begin
            for (int b = 0; b < 2; b++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int e = 0; e < 6; e++) begin
                        for (int d = 0; d < 2; d++) begin
                            n++;
                            run_access(d[0], 2'(w), b[0], r[0], be_set[e],
                                       32'hA1B2C3D4 ^ (32'(n) * 32'h01010101),
                                       26'(32'h0123457 + n * 3));
                        end
                    end
                end
            end
        end
        // Upper width code behaves as 32 bits.
        run_access(1'b1, 2'b11, 1'b0, 1'b1, 4'b1001, 32'hDEADBEEF, 26'h2AAAAAA);
        run_access(1'b0, 2'b11, 1'b1, 1'b0, 4'b0111, 32'h0, 26'h1555555);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule